// File: doc/BRIEF.md
# Packed 16-bit Multiply Unit

This block multiplies two 64-bit operands lane by lane. Each operand is four independent 16-bit lanes. A 2-bit mode chosen with each operation picks what comes back. It can be the signed upper half, the low half or the unsigned upper half of every 32-bit lane product. It can also be a multiply-add that sums neighbouring signed products into two 32-bit words.

The datapath is a three-stage pipeline. The stages are operand capture, lane products and result formatting. A new operation can enter on every clock, and each operation carries its own mode. The result and its valid flag appear exactly three rising edges after the operation is accepted, whatever the mode. A host therefore schedules the write-back of a multiply by counting cycles and needs no handshake.

Top module: `pmul16x4`

## Requirements
- R1: Lane i of a 64-bit word occupies bits [16i+15:16i]; each lane result depends only on lane i of both operands, in every mode except multiply-add.
- R2: Mode 2'b00 (signed high) returns, in each lane, bits [31:16] of the two's-complement product of the two signed 16-bit lane values.
- R3: Mode 2'b01 (low) returns, in each lane, bits [15:0] of the lane product.
- R4: Mode 2'b10 (unsigned high) returns, in each lane, bits [31:16] of the product of the two lane values read as unsigned numbers.
- R5: Mode 2'b11 (multiply-add) forms the four signed lane products. Result bits [31:0] hold product0 + product1 and bits [63:32] hold product2 + product3.
- R6: Multiply-add sums wrap modulo 2^32; when all four lanes of both operands are 16'h8000 the result is 64'h80000000_80000000.
- R7: An operation sampled with in_valid high on a rising edge shows its result on out_result, with out_valid high, after the third rising edge counted from that one, and out_valid is high for that one cycle only.
- R8: Operations may be presented on consecutive cycles with different modes; each one comes out in order, three edges later, with the result of its own mode.
- R9: A rising edge with rst_n low clears every pipeline valid bit: out_valid is low after it, and no operation accepted before the reset appears afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation present on the inputs this cycle |
| in_mode | input | 2 | 00 signed high, 01 low, 10 unsigned high, 11 multiply-add |
| in_a | input | 64 | First operand, four 16-bit lanes |
| in_b | input | 64 | Second operand, four 16-bit lanes |
| out_valid | output | 1 | out_result holds a finished operation |
| out_result | output | 64 | Formatted result |

## Verification
A mode that is lost or mis-staged shows up as the wrong half or the wrong signedness in the result. This happens exactly three edges after the affected operation, so back-to-back operations with alternating modes expose it at once. A product register loaded from a neighbouring lane shows up as a lane result that moves when only another lane's operand changes. A stale or uncleared valid bit makes out_valid rise on the wrong cycle, or after a reset, within three edges of the cause.

// File: rtl/pmul_pkg.sv
// pmul_pkg: shared mode encoding for the packed multiply unit.
// Assumes the mode travels with its operation through every stage.
package pmul_pkg;
    typedef enum logic [1:0] {
        PM_SHI  = 2'b00,
        PM_LO   = 2'b01,
        PM_UHI  = 2'b10,
        PM_MADD = 2'b11
    } pmul_mode_e;
endpackage

// File: rtl/pmul_lane.sv
// pmul_lane: one lane multiplier of the second pipeline stage.
// Both operands are widened by one bit, sign-extended unless the mode is
// unsigned high, so a single signed multiplier serves every mode. The product
// register loads only when the stage ahead holds a valid operation.
module pmul_lane
    import pmul_pkg::*;
#(
    parameter int unsigned LANE_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en,
    input  pmul_mode_e            mode,
    input  logic [LANE_W-1:0]     a,
    input  logic [LANE_W-1:0]     b,
    output logic [2*LANE_W-1:0]   prod
);
    localparam int unsigned PW = 2 * LANE_W;

    logic                 sign_en;
    logic signed [LANE_W:0] ax;
    logic signed [LANE_W:0] bx;
    logic signed [PW+1:0] full;

    // Widen both operands according to the signedness of the mode.
    always_comb begin
        sign_en = (mode != PM_UHI);
        ax      = $signed({sign_en & a[LANE_W-1], a});
        bx      = $signed({sign_en & b[LANE_W-1], b});
        full    = ax * bx;
    end

    // Register the low 2*LANE_W bits of the product (all that any mode uses).
    always_ff @(posedge clk) begin
        if (en) prod <= full[PW-1:0];
    end

    // R1
    zero_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && a == '0) |=> (prod == '0));
endmodule

// File: rtl/pmul_fmt.sv
// pmul_fmt: third stage, turns the lane products into the final word.
// Assumes LANES is even; multiply-add pairs lanes 2p and 2p+1 into a
// 2*LANE_W-bit sum that wraps. The result register holds when en is low.
module pmul_fmt
    import pmul_pkg::*;
#(
    parameter int unsigned LANE_W = 16,
    parameter int unsigned LANES  = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        en,
    input  pmul_mode_e                  mode,
    input  logic [LANES*2*LANE_W-1:0]   prods,
    output logic [LANES*LANE_W-1:0]     result
);
    localparam int unsigned PW    = 2 * LANE_W;
    localparam int unsigned W     = LANES * LANE_W;
    localparam int unsigned PAIRS = LANES / 2;

    logic [W-1:0] lane_word;
    logic [W-1:0] madd_word;

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_pick
            // Choose the low or high half of lane i's product.
            always_comb begin
                lane_word[i*LANE_W +: LANE_W] = (mode == PM_LO)
                    ? prods[i*PW +: LANE_W]
                    : prods[i*PW + LANE_W +: LANE_W];
            end
        end
        for (genvar p = 0; p < PAIRS; p++) begin : g_pair
            // Sum neighbouring signed products, wrapping at PW bits.
            always_comb begin
                madd_word[p*PW +: PW] = prods[(2*p)*PW +: PW]
                                      + prods[(2*p+1)*PW +: PW];
            end
        end
    endgenerate

    // Register the word selected by the mode of the operation in this stage.
    always_ff @(posedge clk) begin
        if (en) result <= (mode == PM_MADD) ? madd_word : lane_word;
    end

    // R3
    lo_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode == PM_LO) |=> (result[LANE_W-1:0] == $past(prods[LANE_W-1:0])));
    // R2
    hi_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode == PM_SHI) |=> (result[LANE_W-1:0] == $past(prods[PW-1:LANE_W])));
endmodule

// File: rtl/pmul16x4.sv
// pmul16x4: packed lane multiplier, three-stage pipeline.
// Stage 1 captures operands and mode, stage 2 holds the lane products,
// stage 3 holds the formatted result. Only valid bits are reset; data
// registers load only behind a valid bit. Assumes LANES is even.
module pmul16x4
    import pmul_pkg::*;
#(
    parameter int unsigned LANE_W = 16,
    parameter int unsigned LANES  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [1:0]               in_mode,
    input  logic [LANES*LANE_W-1:0]  in_a,
    input  logic [LANES*LANE_W-1:0]  in_b,
    output logic                     out_valid,
    output logic [LANES*LANE_W-1:0]  out_result
);
    localparam int unsigned W  = LANES * LANE_W;
    localparam int unsigned PW = 2 * LANE_W;

    logic         v1, v2, v3;
    pmul_mode_e   m1, m2;
    logic [W-1:0] a1, b1;
    logic [LANES*PW-1:0] prods;

    // Advance the valid bits; a low rst_n on an edge empties the pipeline.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1 <= 1'b0;
            v2 <= 1'b0;
            v3 <= 1'b0;
        end else begin
            v1 <= in_valid;
            v2 <= v1;
            v3 <= v2;
        end
    end

    // Capture operands and mode of an accepted operation.
    always_ff @(posedge clk) begin
        if (in_valid) begin
            a1 <= in_a;
            b1 <= in_b;
            m1 <= pmul_mode_e'(in_mode);
        end
    end

    // Carry the mode alongside the products.
    always_ff @(posedge clk) begin
        if (v1) m2 <= m1;
    end

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            pmul_lane #(.LANE_W(LANE_W)) u_lane (
                .clk  (clk),
                .rst_n(rst_n),
                .en   (v1),
                .mode (m1),
                .a    (a1[i*LANE_W +: LANE_W]),
                .b    (b1[i*LANE_W +: LANE_W]),
                .prod (prods[i*PW +: PW])
            );
        end
    endgenerate

    pmul_fmt #(.LANE_W(LANE_W), .LANES(LANES)) u_fmt (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (v2),
        .mode  (m2),
        .prods (prods),
        .result(out_result)
    );

    assign out_valid = v3;

    // Edges since reset release, saturating at 3, for the latency check.
    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (!rst_n)          age <= 2'd0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    // R7
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3) |-> (out_valid == $past(in_valid, 3)));
    // R9
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> !out_valid);
endmodule

// File: tb/pmul16x4_bench.sv
// pmul16x4_bench: streams a stimulus table through the pipeline, then runs
// directed latency, corner-case and reset tests.
module pmul16x4_bench;
    localparam int NV = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_mode = 2'b00;
    logic [63:0] in_a = '0;
    logic [63:0] in_b = '0;
    logic        out_valid;
    logic [63:0] out_result;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    pmul16x4 u_pmul16x4 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
        .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_result(out_result)
    );

    // Stimulus table: operand A, operand B, mode.
    localparam logic [63:0] TA [NV] = '{
        64'h0001_0002_0003_0004, 64'hFFFF_8000_7FFF_1234, 64'hFFFF_8000_7FFF_1234,
        64'hFFFF_8000_7FFF_1234, 64'hFFFF_8000_7FFF_1234, 64'h0000_0000_0000_ABCD,
        64'h7FFF_7FFF_8000_8000, 64'h1234_5678_9ABC_DEF0, 64'h00FF_FF00_0F0F_F0F0,
        64'hC000_4000_FFFE_0002};
    localparam logic [63:0] TB [NV] = '{
        64'h0005_0006_0007_0008, 64'hFFFF_8000_7FFF_5678, 64'hFFFF_8000_7FFF_5678,
        64'hFFFF_8000_7FFF_5678, 64'hFFFF_8000_7FFF_5678, 64'h0000_0000_0000_BEEF,
        64'h7FFF_8000_7FFF_8000, 64'hFEDC_BA98_7654_3210, 64'hFF00_00FF_F0F0_0F0F,
        64'h4000_C000_0003_FFFD};
    localparam logic [1:0] TM [NV] = '{
        2'b11, 2'b00, 2'b01, 2'b10, 2'b11, 2'b10, 2'b11, 2'b00, 2'b01, 2'b11};

    // Expected result worked out from the requirements.
    function automatic logic [63:0] model(logic [63:0] a, logic [63:0] b, logic [1:0] m);
        logic [63:0] r;
        longint p [4];
        for (int l = 0; l < 4; l++) begin
            longint x, y;
            x = (m == 2'b10) ? longint'({48'd0, a[16*l +: 16]}) : longint'($signed(a[16*l +: 16]));
            y = (m == 2'b10) ? longint'({48'd0, b[16*l +: 16]}) : longint'($signed(b[16*l +: 16]));
            p[l] = x * y;
            r[16*l +: 16] = (m == 2'b01) ? p[l][15:0] : p[l][31:16];
        end
        if (m == 2'b11) begin
            longint s0, s1;
            s0 = p[0] + p[1];
            s1 = p[2] + p[3];
            r = {s1[31:0], s0[31:0]};
        end
        return r;
    endfunction

    function automatic string tag_of(logic [1:0] m);
        case (m)
            2'b00:   return "R2";
            2'b01:   return "R3";
            2'b10:   return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check1(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // Issue one operation, then idle three edges and check its result (R7).
    task automatic single(string tag, logic [63:0] a, logic [63:0] b, logic [1:0] m, logic [63:0] exp);
        in_valid = 1'b1; in_a = a; in_b = b; in_mode = m;
        step();
        in_valid = 1'b0; in_a = '0; in_b = '0;
        check1("R7 early", out_valid, 1'b0);
        step();
        check1("R7 early", out_valid, 1'b0);
        step();
        check1("R7 valid", out_valid, 1'b1);
        check64(tag, out_result, exp);
        step();
        check1("R7 one cycle", out_valid, 1'b0);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        step();
        step();
        check1("R9 reset", out_valid, 1'b0);
        rst_n = 1'b1;

        // R8: stream the table back to back, checking vector k-3 at negedge k.
        for (int k = 0; k < NV + 3; k++) begin
            if (k >= 3) begin
                check1("R8 valid", out_valid, 1'b1);
                check64(tag_of(TM[k-3]), out_result, model(TA[k-3], TB[k-3], TM[k-3]));
            end
            if (k < NV) begin
                in_valid = 1'b1; in_a = TA[k]; in_b = TB[k]; in_mode = TM[k];
            end else begin
                in_valid = 1'b0;
            end
            step();
        end
        check1("R8 drain", out_valid, 1'b0);

        // Directed corner cases with hand-worked results.
        single("R6 wrap", 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, 2'b11, 64'h80000000_80000000);
        single("R2 min*min", 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, 2'b00, 64'h4000_4000_4000_4000);
        single("R4 max*max", 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 2'b10, 64'hFFFE_FFFE_FFFE_FFFE);
        single("R2 neg*neg", 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 2'b00, 64'h0000_0000_0000_0000);
        single("R3 low", 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 2'b01, 64'h0001_0001_0001_0001);
        // R1: only lane 2 is non-zero, the other lanes must stay zero.
        single("R1 lane", 64'h0000_0100_0000_0000, 64'h0000_0300_0000_0000, 2'b01, 64'h0000_0000_0000_0000);
        single("R1 lane", 64'h0000_0100_0000_0000, 64'h0000_0300_0000_0000, 2'b00, 64'h0000_0003_0000_0000);

        // R9: reset while operations are in flight; none may come out.
        in_valid = 1'b1; in_a = 64'h1; in_b = 64'h1; in_mode = 2'b01;
        step();
        step();
        rst_n = 1'b0;
        step();
        check1("R9 reset", out_valid, 1'b0);
        rst_n = 1'b1;
        in_valid = 1'b0;
        for (int k = 0; k < 4; k++) begin
            step();
            check1("R9 flushed", out_valid, 1'b0);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule